// File: doc/BRIEF.md
# Trap and Privilege Control Unit

This block is the system-control corner of a simple 32-bit processor. It receives trap requests from the core: a synchronous fault with a reason code and a faulting address, a system-call request and a timer tick. When a trap is taken it saves the core's current PC and a reason code, captures the faulting virtual address for page faults, enters kernel mode, clears the exception-enable bit and, one cycle later, steers fetch to a fixed trap vector. A return-from-trap request leaves kernel mode, sets exception-enable again and steers fetch back to the saved PC.

Software reaches the four control registers through a move-to and move-from port: saved PC, reason, status and faulting address. The registers are readable and writable only in kernel mode. A register access or a return request made in user mode becomes a trap of its own. A fault taken while exceptions are disabled leaves the saved PC and reason alone and goes to a separate double-fault vector. Any further fault during double-fault handling halts the block until reset.

A four-state machine sequences the block. BOOT is entered at reset and steers fetch to the boot address for one cycle. It always moves on to RUN, the normal state. RUN moves to DFAULT on a fault taken with exceptions disabled. DFAULT moves back to RUN on a return request, or to HALT on any further fault or system call. HALT is left only by reset.

Top module: `trap_priv_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `redirect_o` is 1 with `redirect_pc_o` = BOOT_ADDR, `kernel_o` is 1, `exc_en_o` is 1 and `halt_o` is 0. Inputs are ignored in that first cycle.
- R2: A trap taken with exceptions enabled makes the next cycle show `redirect_o`=1 with `redirect_pc_o`=TRAP_VEC, `kernel_o`=1 and `exc_en_o`=0. It loads the saved PC with `pc_i` and the reason with its code.
- R3: The faulting-address register is loaded from `fault_addr_i` only by a taken trap with reason 1 (page fault). All other reasons leave it unchanged.
- R4: Reason codes are 0 system call, 1 page fault, 2 protection, 3 divide by zero, 4 overflow, 5 illegal opcode, 6 privileged access in user mode, 7 timer tick. A core fault uses `fault_code_i` (1..5). Priority within one cycle is: core fault, then privileged-access fault, then system call, then timer tick, then return, then register write.
- R5: A tick is held pending until it is taken with exceptions enabled, as a trap with reason 7, and the pending flag then clears.
- R6: In user mode, a register write, a register read (`csr_rd_i`) or a return request raises a reason-6 trap. The addressed register is not written, and `csr_rdata_o` reads 0 in user mode.
- R7: A return request in kernel mode redirects fetch to the saved PC the next cycle, sets `kernel_o`=0 and `exc_en_o`=1, and leaves DFAULT for RUN.
- R8: A fault or system call while `exc_en_o`=0 redirects to DBL_VEC and enters DFAULT. The saved PC and reason stay unchanged.
- R9: A fault or system call in DFAULT raises `halt_o`, which stays 1 until reset. No redirect occurs in HALT and all requests are ignored there.
- R10: In kernel mode `csr_sel_i` selects 0 saved PC, 1 reason (bits 2:0), 2 status, 3 faulting address. Reads are combinational. A write takes effect at the clock edge. Status bit 0 is kernel mode, bit 1 is exception-enable and bit 2 (read only) is 1 in DFAULT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | XLEN | PC of the instruction in the trapping stage |
| fault_i | input | 1 | Core fault request |
| fault_code_i | input | 3 | Reason code of the core fault |
| fault_addr_i | input | XLEN | Faulting virtual address |
| syscall_i | input | 1 | System-call request |
| tick_i | input | 1 | Timer tick request |
| eret_i | input | 1 | Return-from-trap request |
| csr_wr_i | input | 1 | Register write request |
| csr_rd_i | input | 1 | Register read request |
| csr_sel_i | input | 2 | Register select |
| csr_wdata_i | input | XLEN | Register write data |
| csr_rdata_o | output | XLEN | Register read data |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | XLEN | Fetch redirect target |
| kernel_o | output | 1 | Kernel-mode flag |
| exc_en_o | output | 1 | Exception-enable flag |
| halt_o | output | 1 | Shutdown output |

## Verification
Two pairs of functions can fall in the same cycle. A core fault can coincide with a system call and a tick. A return request can coincide with a tick that is still pending. The bench drives a page fault, a system call and a tick in one cycle and expects reason 1 with the tick left pending. Its next step is a return, and it expects the tick trap to be taken only in the cycle after exceptions are enabled again, with the saved PC taken from that later cycle. A behavioural reference model is compared against every output on every clock, and directed reads of the registers confirm the saved values.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [2:0] {
        C_SYSCALL = 3'd0,
        C_PAGE    = 3'd1,
        C_PROT    = 3'd2,
        C_DIV0    = 3'd3,
        C_OVF     = 3'd4,
        C_ILL     = 3'd5,
        C_PRIV    = 3'd6,
        C_TICK    = 3'd7
    } cause_e;

    typedef enum logic [1:0] {
        SEL_EPC    = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_BADVA  = 2'd3
    } csr_sel_e;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DFAULT = 2'd2,
        ST_HALT   = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_TRAP = 3'd1,
        ACT_DBL  = 3'd2,
        ACT_HALT = 3'd3,
        ACT_RET  = 3'd4,
        ACT_CSRW = 3'd5
    } act_e;

    localparam int STAT_KERNEL_BIT = 0;
    localparam int STAT_EN_BIT     = 1;
    localparam int STAT_DBL_BIT    = 2;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  seq_state_e state_i,
    input  logic       kernel_i,
    input  logic       exc_en_i,
    input  logic       fault_i,
    input  logic [2:0] fault_code_i,
    input  logic       syscall_i,
    input  logic       tick_any_i,
    input  logic       eret_i,
    input  logic       csr_wr_i,
    input  logic       csr_rd_i,
    output act_e       act_o,
    output cause_e     cause_o
);

    logic   priv_viol;
    logic   sync_fault;
    cause_e fcode;

    assign priv_viol  = !kernel_i && (csr_wr_i || csr_rd_i || eret_i);
    assign sync_fault = fault_i || priv_viol;
    assign fcode      = fault_i ? cause_e'(fault_code_i) : C_PRIV;

    always_comb begin
        act_o   = ACT_NONE;
        cause_o = C_SYSCALL;
        unique case (state_i)
            ST_BOOT, ST_HALT: begin
                act_o = ACT_NONE;
            end
            ST_RUN: begin
                if (sync_fault) begin
                    cause_o = fcode;
                    act_o   = exc_en_i ? ACT_TRAP : ACT_DBL;
                end else if (syscall_i) begin
                    cause_o = C_SYSCALL;
                    act_o   = exc_en_i ? ACT_TRAP : ACT_DBL;
                end else if (tick_any_i && exc_en_i) begin
                    cause_o = C_TICK;
                    act_o   = ACT_TRAP;
                end else if (eret_i) begin
                    act_o = ACT_RET;
                end else if (csr_wr_i) begin
                    act_o = ACT_CSRW;
                end
            end
            ST_DFAULT: begin
                if (sync_fault || syscall_i) begin
                    act_o = ACT_HALT;
                end else if (eret_i) begin
                    act_o = ACT_RET;
                end else if (csr_wr_i) begin
                    act_o = ACT_CSRW;
                end
            end
        endcase
    end

endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  act_e            act_i,
    input  cause_e          cause_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] fault_addr_i,
    input  logic            tick_i,
    input  logic [1:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    input  logic            in_dfault_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic [XLEN-1:0] epc_o,
    output logic [2:0]      cause_o,
    output logic [XLEN-1:0] badva_o,
    output logic            kernel_o,
    output logic            exc_en_o,
    output logic            tick_pend_o
);

    localparam int STAT_W = STAT_DBL_BIT + 1;

    logic [XLEN-1:0]   epc_q, badva_q;
    logic [2:0]        cause_q;
    logic              kernel_q, en_q, tick_q;
    logic [STAT_W-1:0] status_w;
    csr_sel_e          sel;

    assign sel = csr_sel_e'(csr_sel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q    <= '0;
            cause_q  <= '0;
            badva_q  <= '0;
            kernel_q <= 1'b1;
            en_q     <= 1'b1;
            tick_q   <= 1'b0;
        end else begin
            tick_q <= (tick_q || tick_i) && !(act_i == ACT_TRAP && cause_i == C_TICK);
            unique case (act_i)
                ACT_TRAP: begin
                    epc_q    <= pc_i;
                    cause_q  <= cause_i;
                    kernel_q <= 1'b1;
                    en_q     <= 1'b0;
                    if (cause_i == C_PAGE) begin
                        badva_q <= fault_addr_i;
                    end
                end
                ACT_DBL: begin
                    kernel_q <= 1'b1;
                end
                ACT_RET: begin
                    kernel_q <= 1'b0;
                    en_q     <= 1'b1;
                end
                ACT_CSRW: begin
                    unique case (sel)
                        SEL_EPC:    epc_q   <= csr_wdata_i;
                        SEL_CAUSE:  cause_q <= csr_wdata_i[2:0];
                        SEL_STATUS: begin
                            kernel_q <= csr_wdata_i[STAT_KERNEL_BIT];
                            en_q     <= csr_wdata_i[STAT_EN_BIT];
                        end
                        SEL_BADVA:  badva_q <= csr_wdata_i;
                    endcase
                end
                ACT_NONE, ACT_HALT: begin
                end
                default: begin
                end
            endcase
        end
    end

    always_comb begin
        status_w                  = '0;
        status_w[STAT_KERNEL_BIT] = kernel_q;
        status_w[STAT_EN_BIT]     = en_q;
        status_w[STAT_DBL_BIT]    = in_dfault_i;
    end

    always_comb begin
        csr_rdata_o = '0;
        if (kernel_q) begin
            unique case (sel)
                SEL_EPC:    csr_rdata_o = epc_q;
                SEL_CAUSE:  csr_rdata_o = {{(XLEN-3){1'b0}}, cause_q};
                SEL_STATUS: csr_rdata_o = {{(XLEN-STAT_W){1'b0}}, status_w};
                SEL_BADVA:  csr_rdata_o = badva_q;
            endcase
        end
    end

    assign epc_o       = epc_q;
    assign cause_o     = cause_q;
    assign badva_o     = badva_q;
    assign kernel_o    = kernel_q;
    assign exc_en_o    = en_q;
    assign tick_pend_o = tick_q;

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] BOOT_ADDR = '0,
    parameter logic [XLEN-1:0] TRAP_VEC  = '0,
    parameter logic [XLEN-1:0] DBL_VEC   = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  act_e            act_i,
    input  logic [XLEN-1:0] epc_i,
    output seq_state_e      state_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            halt_o
);

    seq_state_e      state_q, state_d;
    logic            redir_q;
    logic [XLEN-1:0] redir_pc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT:   state_d = ST_RUN;
            ST_RUN:    if (act_i == ACT_DBL) state_d = ST_DFAULT;
            ST_DFAULT: begin
                if (act_i == ACT_HALT)     state_d = ST_HALT;
                else if (act_i == ACT_RET) state_d = ST_RUN;
            end
            ST_HALT:   state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redir_q    <= 1'b0;
            redir_pc_q <= BOOT_ADDR;
        end else begin
            redir_q <= (act_i == ACT_TRAP) || (act_i == ACT_DBL) || (act_i == ACT_RET);
            unique case (act_i)
                ACT_TRAP: redir_pc_q <= TRAP_VEC;
                ACT_DBL:  redir_pc_q <= DBL_VEC;
                ACT_RET:  redir_pc_q <= epc_i;
                default:  redir_pc_q <= redir_pc_q;
            endcase
        end
    end

    assign state_o       = state_q;
    assign redirect_o    = (state_q == ST_BOOT) || redir_q;
    assign redirect_pc_o = (state_q == ST_BOOT) ? BOOT_ADDR : redir_pc_q;
    assign halt_o        = (state_q == ST_HALT);

endmodule

// File: rtl/trap_priv_ctrl.sv
module trap_priv_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_0100,
    parameter logic [XLEN-1:0] TRAP_VEC  = 32'h0000_0080,
    parameter logic [XLEN-1:0] DBL_VEC   = 32'h0000_00C0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pc_i,
    input  logic            fault_i,
    input  logic [2:0]      fault_code_i,
    input  logic [XLEN-1:0] fault_addr_i,
    input  logic            syscall_i,
    input  logic            tick_i,
    input  logic            eret_i,
    input  logic            csr_wr_i,
    input  logic            csr_rd_i,
    input  logic [1:0]      csr_sel_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] csr_rdata_o,
    output logic            redirect_o,
    output logic [XLEN-1:0] redirect_pc_o,
    output logic            kernel_o,
    output logic            exc_en_o,
    output logic            halt_o
);

    seq_state_e      state;
    act_e            act;
    cause_e          cause_sel;
    logic [XLEN-1:0] epc_w, badva_w;
    logic [2:0]      cause_w;
    logic            kernel_w, en_w, tick_pend_w;

    trap_arbiter u_arb (
        .state_i      (state),
        .kernel_i     (kernel_w),
        .exc_en_i     (en_w),
        .fault_i      (fault_i),
        .fault_code_i (fault_code_i),
        .syscall_i    (syscall_i),
        .tick_any_i   (tick_pend_w || tick_i),
        .eret_i       (eret_i),
        .csr_wr_i     (csr_wr_i),
        .csr_rd_i     (csr_rd_i),
        .act_o        (act),
        .cause_o      (cause_sel)
    );

    trap_csr_file #(.XLEN(XLEN)) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (act),
        .cause_i      (cause_sel),
        .pc_i         (pc_i),
        .fault_addr_i (fault_addr_i),
        .tick_i       (tick_i),
        .csr_sel_i    (csr_sel_i),
        .csr_wdata_i  (csr_wdata_i),
        .in_dfault_i  (state == ST_DFAULT),
        .csr_rdata_o  (csr_rdata_o),
        .epc_o        (epc_w),
        .cause_o      (cause_w),
        .badva_o      (badva_w),
        .kernel_o     (kernel_w),
        .exc_en_o     (en_w),
        .tick_pend_o  (tick_pend_w)
    );

    trap_seq_fsm #(
        .XLEN      (XLEN),
        .BOOT_ADDR (BOOT_ADDR),
        .TRAP_VEC  (TRAP_VEC),
        .DBL_VEC   (DBL_VEC)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .act_i         (act),
        .epc_i         (epc_w),
        .state_o       (state),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .halt_o        (halt_o)
    );

    assign kernel_o = kernel_w;
    assign exc_en_o = en_w;

endmodule

// File: rtl/trap_priv_chk.sv
module trap_priv_chk
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] TRAP_VEC = '0,
    parameter logic [XLEN-1:0] DBL_VEC  = '0
) (
    input logic            clk,
    input logic            rst_n,
    input act_e            act,
    input logic            kernel_o,
    input logic            exc_en_o,
    input logic            halt_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] redirect_pc_o,
    input logic [XLEN-1:0] epc_w,
    input logic [2:0]      cause_w,
    input logic [XLEN-1:0] badva_w,
    input logic            fault_i,
    input logic            csr_wr_i,
    input logic [1:0]      csr_sel_i
);

    p_trap_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |=> redirect_o && redirect_pc_o == TRAP_VEC && kernel_o && !exc_en_o);

    p_trap_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_TRAP |-> exc_en_o);

    p_user_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr_i && !kernel_o && csr_sel_i == 2'd3 && !fault_i) |=> $stable(badva_w));

    p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_RET |=> redirect_o && !kernel_o && exc_en_o);

    p_dbl_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_DBL |=> $stable(epc_w) && $stable(cause_w) && redirect_pc_o == DBL_VEC);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> !redirect_o);

endmodule

bind trap_priv_ctrl trap_priv_chk #(
    .XLEN     (XLEN),
    .TRAP_VEC (TRAP_VEC),
    .DBL_VEC  (DBL_VEC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .act           (act),
    .kernel_o      (kernel_o),
    .exc_en_o      (exc_en_o),
    .halt_o        (halt_o),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .epc_w         (epc_w),
    .cause_w       (cause_w),
    .badva_w       (badva_w),
    .fault_i       (fault_i),
    .csr_wr_i      (csr_wr_i),
    .csr_sel_i     (csr_sel_i)
);

// File: tb/trap_priv_ctrl_tb.sv
`timescale 1ns/1ps
module trap_priv_ctrl_tb;

    localparam logic [31:0] BOOT = 32'h0000_0100;
    localparam logic [31:0] TV   = 32'h0000_0080;
    localparam logic [31:0] DV   = 32'h0000_00C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_i = '0, fault_addr_i = '0, csr_wdata_i = '0;
    logic        fault_i = 0, syscall_i = 0, tick_i = 0, eret_i = 0, csr_wr_i = 0, csr_rd_i = 0;
    logic [2:0]  fault_code_i = '0;
    logic [1:0]  csr_sel_i = '0;
    logic [31:0] csr_rdata_o, redirect_pc_o;
    logic        redirect_o, kernel_o, exc_en_o, halt_o;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trap_priv_ctrl #(.XLEN(32), .BOOT_ADDR(BOOT), .TRAP_VEC(TV), .DBL_VEC(DV)) u_dut (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .fault_i(fault_i), .fault_code_i(fault_code_i),
        .fault_addr_i(fault_addr_i), .syscall_i(syscall_i), .tick_i(tick_i), .eret_i(eret_i),
        .csr_wr_i(csr_wr_i), .csr_rd_i(csr_rd_i), .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i),
        .csr_rdata_o(csr_rdata_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .kernel_o(kernel_o), .exc_en_o(exc_en_o), .halt_o(halt_o)
    );

    // behavioural reference model (0 boot, 1 run, 2 double fault, 3 halt)
    int          m_st;
    bit          m_k, m_en, m_tp, m_redir;
    logic [31:0] m_epc, m_bad, m_rpc;
    int          m_cause;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_k = 1; m_en = 1; m_tp = 0; m_redir = 0;
            m_epc = 0; m_bad = 0; m_rpc = BOOT; m_cause = 0;
        end else begin
            bit tick_seen, user_bad, do_trap, do_dbl, do_halt, do_ret, do_wr;
            int why;
            tick_seen = m_tp || tick_i;
            user_bad  = !m_k && (csr_wr_i || csr_rd_i || eret_i);
            do_trap = 0; do_dbl = 0; do_halt = 0; do_ret = 0; do_wr = 0; why = 0;
            if (m_st == 1) begin
                if (fault_i || user_bad || syscall_i) begin
                    why = fault_i ? int'(fault_code_i) : (user_bad ? 6 : 0);
                    if (m_en) do_trap = 1; else do_dbl = 1;
                end else if (tick_seen && m_en) begin
                    why = 7; do_trap = 1;
                end else if (eret_i) do_ret = 1;
                else if (csr_wr_i) do_wr = 1;
            end else if (m_st == 2) begin
                if (fault_i || user_bad || syscall_i) do_halt = 1;
                else if (eret_i) do_ret = 1;
                else if (csr_wr_i) do_wr = 1;
            end
            m_redir = do_trap || do_dbl || do_ret;
            if (do_trap) m_rpc = TV;
            else if (do_dbl) m_rpc = DV;
            else if (do_ret) m_rpc = m_epc;
            m_tp = tick_seen && !(do_trap && why == 7);
            if (do_trap) begin
                m_epc = pc_i; m_cause = why; m_k = 1; m_en = 0;
                if (why == 1) m_bad = fault_addr_i;
            end
            if (do_dbl) m_k = 1;
            if (do_ret) begin m_k = 0; m_en = 1; end
            if (do_wr) begin
                case (csr_sel_i)
                    2'd0: m_epc = csr_wdata_i;
                    2'd1: m_cause = int'(csr_wdata_i[2:0]);
                    2'd2: begin m_k = csr_wdata_i[0]; m_en = csr_wdata_i[1]; end
                    default: m_bad = csr_wdata_i;
                endcase
            end
            if (m_st == 0) m_st = 1;
            else if (m_st == 1 && do_dbl) m_st = 2;
            else if (m_st == 2 && do_halt) m_st = 3;
            else if (m_st == 2 && do_ret) m_st = 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read();
        if (!m_k) return 32'h0;
        case (csr_sel_i)
            2'd0: return m_epc;
            2'd1: return 32'(m_cause);
            2'd2: return {29'h0, (m_st == 2), m_en, m_k};
            default: return m_bad;
        endcase
    endfunction

    task automatic compare_all();
        chk("R2 redirect", {31'h0, redirect_o}, {31'h0, (m_st == 0) || m_redir});
        if (redirect_o) chk("R2 redirect_pc", redirect_pc_o, (m_st == 0) ? BOOT : m_rpc);
        chk("R2 kernel", {31'h0, kernel_o}, {31'h0, m_k});
        chk("R2 exc_en", {31'h0, exc_en_o}, {31'h0, m_en});
        chk("R9 halt", {31'h0, halt_o}, {31'h0, m_st == 3});
        chk("R10 rdata", csr_rdata_o, m_read());
    endtask

    task automatic idle();
        fault_i = 0; syscall_i = 0; tick_i = 0; eret_i = 0; csr_wr_i = 0; csr_rd_i = 0;
        fault_code_i = 0; csr_sel_i = 0; csr_wdata_i = 0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare_all();
        idle();
    endtask

    task automatic peek(input logic [1:0] sel, output logic [31:0] v);
        csr_sel_i = sel;
        #1;
        v = csr_rdata_o;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        #0.5;
        chk("R1 boot redirect", {31'h0, redirect_o}, 32'h1);
        chk("R1 boot pc", redirect_pc_o, BOOT);
        chk("R1 kernel", {31'h0, kernel_o}, 32'h1);
        chk("R1 exc_en", {31'h0, exc_en_o}, 32'h1);
        chk("R1 halt", {31'h0, halt_o}, 32'h0);
        fault_i = 1; fault_code_i = 3'd2;
        cyc();
        chk("R1 boot ignores fault", {31'h0, redirect_o}, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] v;
        do_reset();

        // R10 kernel writes and reads
        csr_wr_i = 1; csr_sel_i = 2'd0; csr_wdata_i = 32'h2000; cyc();
        peek(2'd0, v); chk("R10 epc write", v, 32'h2000);
        csr_wr_i = 1; csr_sel_i = 2'd2; csr_wdata_i = 32'h2; cyc();
        chk("R10 status to user", {31'h0, kernel_o}, 32'h0);
        peek(2'd0, v); chk("R6 user read zero", v, 32'h0);

        // R6 user read traps
        pc_i = 32'h3000; csr_rd_i = 1; csr_sel_i = 2'd0; cyc();
        chk("R6 priv trap redirect", redirect_pc_o, TV);
        peek(2'd1, v); chk("R6 cause 6", v, 32'd6);
        peek(2'd0, v); chk("R2 epc saved", v, 32'h3000);

        // R7 return, then user write to faulting-address reg is blocked
        eret_i = 1; cyc();
        chk("R7 return target", redirect_pc_o, 32'h3000);
        chk("R7 user mode", {31'h0, kernel_o}, 32'h0);
        pc_i = 32'h3100; csr_wr_i = 1; csr_sel_i = 2'd3; csr_wdata_i = 32'h5555; cyc();
        peek(2'd3, v); chk("R6 badva unchanged", v, 32'h0);

        // R4 R3 R5 fault + syscall + tick in one cycle
        eret_i = 1; cyc();
        pc_i = 32'h4000; fault_i = 1; fault_code_i = 3'd1; fault_addr_i = 32'hDEAD0;
        syscall_i = 1; tick_i = 1; cyc();
        peek(2'd1, v); chk("R4 fault wins", v, 32'd1);
        peek(2'd3, v); chk("R3 badva loaded", v, 32'hDEAD0);
        pc_i = 32'h4004; cyc();
        chk("R5 tick held while disabled", {31'h0, redirect_o}, 32'h0);
        eret_i = 1; cyc();
        chk("R7 return to 4000", redirect_pc_o, 32'h4000);
        pc_i = 32'h4000; cyc();
        chk("R5 tick trap", redirect_pc_o, TV);
        peek(2'd1, v); chk("R5 cause 7", v, 32'd7);
        eret_i = 1; cyc();
        cyc();
        chk("R5 tick cleared", {31'h0, redirect_o}, 32'h0);

        // R4 syscall alone, R3 badva kept
        pc_i = 32'h5000; syscall_i = 1; cyc();
        peek(2'd1, v); chk("R4 syscall cause 0", v, 32'd0);
        peek(2'd3, v); chk("R3 badva kept", v, 32'hDEAD0);

        // R8 double fault
        pc_i = 32'h5100; fault_i = 1; fault_code_i = 3'd3; cyc();
        chk("R8 dbl vector", redirect_pc_o, DV);
        peek(2'd1, v); chk("R8 cause kept", v, 32'd0);
        peek(2'd0, v); chk("R8 epc kept", v, 32'h5000);
        peek(2'd2, v); chk("R8 status dbl", v, 32'h5);
        eret_i = 1; cyc();
        chk("R7 leave double fault", redirect_pc_o, 32'h5000);
        chk("R7 exc_en back", {31'h0, exc_en_o}, 32'h1);

        // R9 triple fault halts
        pc_i = 32'h6000; syscall_i = 1; cyc();
        fault_i = 1; fault_code_i = 3'd4; cyc();
        fault_i = 1; fault_code_i = 3'd2; cyc();
        chk("R9 halt raised", {31'h0, halt_o}, 32'h1);
        chk("R9 no redirect at halt", {31'h0, redirect_o}, 32'h0);
        syscall_i = 1; cyc();
        eret_i = 1; cyc();
        tick_i = 1; cyc();
        chk("R9 halt sticky", {31'h0, halt_o}, 32'h1);
        chk("R9 no redirect later", {31'h0, redirect_o}, 32'h0);

        do_reset();
        finish_run();
    end

    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule